// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block counts down a programmable interval on a slow timebase of about 32 kHz. That timebase enters the block as a one-cycle enable, `tick_i`, in the system clock domain. Three registers on a small synchronous port set it up:

- **Reload value.** Writing this register loads the down-counter and starts the first stage.
- **Configuration word.** It holds the power-of-two divider for the timebase, a bit that gates the timebase off, and one action code for each of the two expiry stages.
- **Sticky status byte.** It records what happened.

When the first stage runs out, the block fires the first-stage action, sets an overflow flag and reloads the counter for a second stage. When the second stage also runs out, the block fires the second-stage action and stops. Software must write the reload value again to restart it. Each action is a single-cycle pulse on one of three outputs: interrupt, SMI or system reset.

Software kicks the watchdog by rewriting the reload value. It clears the record of past events by writing 1 to the overflow flag, and that same write also clears the three read-only event flags.

Top module: `wdog2`

## Requirements
- R1: After reset every register reads zero and all three action outputs are low, so no action is taken until the block is programmed.
- R2: Register addresses are 0 for the reload value (16 bits, read/write), 2 for configuration and 4 for status. Configuration bits [8:0] are writable. Configuration bits [15:9], status bits [15:4] and any other address read 0, and a write does not change them.
- R3: A write to the reload register loads the counter, restarts the timebase divider and returns to stage one. A reload value of zero stops counting, so no action fires.
- R4: Configuration bits [3:0] give p, and the counter steps once every 2^p enabled ticks. Values 14 and 15 behave as 13. With reload value N, stage one expires on the (N·2^p)-th enabled tick after the reload write.
- R5: While configuration bit 8 is 1, ticks are ignored and the counter holds. Once the bit is cleared, counting resumes.
- R6: At stage-one expiry the block issues a one-cycle pulse chosen by configuration bits [5:4]: 00 none, 01 `irq_o`, 10 `smi_o`, 11 `sysrst_o`. At most one output is high in any cycle.
- R7: Stage-one expiry sets status bit 0 and reloads the counter. A further N·2^p ticks later the action in bits [7:6] fires with the same encoding, and then the block halts until the next reload write.
- R8: Status bits 1, 2 and 3 become 1 together with an interrupt, SMI or reset pulse respectively. They stay set, and software writes to them have no effect.
- R9: Writing status with bit 0 = 1 clears status bits [3:0]. Writing status with bit 0 = 0 changes nothing.
- R10: If a clearing status write lands on the same clock edge as an expiry, the flags set by that expiry survive.
- R11: Any configuration write restarts the divider, so the next counter step comes a full 2^p ticks after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick_i | input | 1 | One-cycle timebase enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt action pulse |
| smi_o | output | 1 | SMI action pulse |
| sysrst_o | output | 1 | System-reset action pulse |

## Verification
Two events can fall on the same clock edge: a stage expiry that sets status flags, and a software write of 1 to the overflow flag that clears them. Random runs place the clearing write on exactly the edge where stage one expires, an edge the bench computes from the reload value and divider. The bench then reads status after stage two and requires every flag from both stages to be present. A second overlap is exercised directly: a configuration rewrite in the middle of a divider period must push the expiry later by the portion of the period already elapsed.

// File: rtl/wdog2.sv
module wdog2 #(
  parameter int CNT_W    = 16,
  parameter int PRES_MAX = 13,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              smi_o,
  output logic              sysrst_o
);
  localparam int PW = PRES_MAX;
  localparam int CFG_W = 9;
  localparam logic [ADDR_W-1:0] A_TMO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(4);

  logic [CNT_W-1:0] tmo_q, cnt_q;
  logic [CFG_W-1:0] cfg_q;
  logic [3:0]       sts_q, sts_d;
  logic [PW-1:0]    pre_q, pre_lim;
  logic [3:0]       pres_eff;
  logic             stage_q, run_q;
  logic             wr_tmo, wr_cfg, wr_sts, tick_en, strobe, expire;
  logic [1:0]       act;
  logic             fire_irq, fire_smi, fire_rst;

  assign wr_tmo = wr_en_i && (addr_i == A_TMO);
  assign wr_cfg = wr_en_i && (addr_i == A_CFG);
  assign wr_sts = wr_en_i && (addr_i == A_STS);

  assign pres_eff = (cfg_q[3:0] > 4'(PRES_MAX)) ? 4'(PRES_MAX) : cfg_q[3:0];
  assign pre_lim  = PW'((32'd1 << pres_eff) - 32'd1);
  assign tick_en  = tick_i && !cfg_q[8];
  assign strobe   = tick_en && (pre_q == pre_lim) && !wr_tmo && !wr_cfg;
  assign expire   = strobe && run_q && (cnt_q == CNT_W'(1));

  assign act      = stage_q ? cfg_q[7:6] : cfg_q[5:4];
  assign fire_irq = expire && (act == 2'b01);
  assign fire_smi = expire && (act == 2'b10);
  assign fire_rst = expire && (act == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (wr_tmo || wr_cfg) pre_q <= '0;
    else if (tick_en)          pre_q <= (pre_q == pre_lim) ? '0 : PW'(pre_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q   <= '0;
      cnt_q   <= '0;
      stage_q <= 1'b0;
      run_q   <= 1'b0;
    end else if (wr_tmo) begin
      tmo_q   <= wdata_i;
      cnt_q   <= wdata_i;
      stage_q <= 1'b0;
      run_q   <= |wdata_i;
    end else if (expire) begin
      if (!stage_q) begin
        cnt_q   <= tmo_q;
        stage_q <= 1'b1;
      end else begin
        run_q   <= 1'b0;
      end
    end else if (strobe && run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_cfg) cfg_q <= wdata_i[CFG_W-1:0];
  end

  always_comb begin
    sts_d = sts_q;
    if (wr_sts && wdata_i[0]) sts_d = '0;
    sts_d = sts_d | {fire_rst, fire_smi, fire_irq, expire && !stage_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q    <= '0;
      irq_o    <= 1'b0;
      smi_o    <= 1'b0;
      sysrst_o <= 1'b0;
    end else begin
      sts_q    <= sts_d;
      irq_o    <= fire_irq;
      smi_o    <= fire_smi;
      sysrst_o <= fire_rst;
    end
  end

  always_comb begin
    case (addr_i)
      A_TMO:   rdata_o = tmo_q;
      A_CFG:   rdata_o = {{(CNT_W-CFG_W){1'b0}}, cfg_q};
      A_STS:   rdata_o = {{(CNT_W-4){1'b0}}, sts_q};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdog2_chk.sv
module wdog2_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic [CNT_W-1:0]  rdata,
  input logic              irq,
  input logic              smi,
  input logic              srst,
  input logic [CNT_W-1:0]  cnt,
  input logic [8:0]        cfg,
  input logic [3:0]        sts
);
  logic clr_wr;
  assign clr_wr = wr_en && (addr == ADDR_W'(4)) && wdata[0];

  // R6
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, smi, srst}));
  // R8
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> sts[1]);
  // R8
  smi_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) smi |-> sts[2]);
  // R8
  rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) srst |-> sts[3]);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sts[3:1] && !clr_wr) |=> ((sts[3:1] & $past(sts[3:1])) == $past(sts[3:1])));
  // R5
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[8] && !wr_en) |=> $stable(cnt));
  // R3
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(0) && wdata == '0) |=> !(irq || smi || srst));
  // R2
  cfg_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(2)) |-> (rdata[CNT_W-1:9] == '0));
endmodule

bind wdog2 wdog2_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
  .rdata(rdata_o), .irq(irq_o), .smi(smi_o), .srst(sysrst_o),
  .cnt(cnt_q), .cfg(cfg_q), .sts(sts_q)
);

// File: tb/wdog2_bench.sv
module wdog2_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_TMO = 3'd0, A_CFG = 3'd2, A_STS = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [15:0] wdata = 16'h0, rdata;
  logic irq, smi, srst;
  int checks = 0, errors = 0;
  logic [15:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog2 u_wdog2 (.clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .smi_o(smi), .sysrst_o(srst));

  function automatic int exp_delay(int n, int p);
    return n << ((p > 13) ? 13 : p);
  endfunction

  function automatic logic [15:0] exp_sts(int a1, int a2);
    return {12'h0, (a1 == 3 || a2 == 3), (a1 == 2 || a2 == 2), (a1 == 1 || a2 == 1), 1'b1};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulses(string req, int a_exp);
    check(req, {irq, smi, srst}, {a_exp == 1, a_exp == 2, a_exp == 3});
  endtask

  // Runs from a reload write just performed; checks outputs on every cycle.
  task automatic run(int d1, int d2, int a1, int a2, int col_k, int cfg_k, logic [15:0] cfg_v,
                     logic [15:0] sts_exp);
    for (int k = 0; k <= d2 + 4; k++) begin
      if (k > 0) begin
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        if (k <= d1) pulses("R6/R4", (k == d1) ? a1 : 0);
        else         pulses("R7", (k == d2) ? a2 : 0);
      end
      if (k + 1 == col_k) begin wr_en = 1'b1; addr = A_STS; wdata = 16'h0001; end
      if (k + 1 == cfg_k) begin wr_en = 1'b1; addr = A_CFG; wdata = cfg_v; end
    end
    rd(A_STS, rv);
    check(col_k != 0 ? "R10" : "R8", rv, sts_exp);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_TMO, rv); check("R1 tmo", rv, 0);
    rd(A_CFG, rv); check("R1 cfg", rv, 0);
    rd(A_STS, rv); check("R1 sts", rv, 0);
    check("R1 outputs", {irq, smi, srst}, 0);

    // R2 map and reserved bits
    wr(A_CFG, 16'hFE3F); rd(A_CFG, rv); check("R2 cfg", rv, 16'h003F);
    wr(A_STS, 16'hFFF0); rd(A_STS, rv); check("R2 sts", rv, 0);
    wr(3'd6, 16'hBEEF);  rd(3'd6, rv);  check("R2 other", rv, 0);
    wr(A_CFG, 16'h0000);
    wr(A_TMO, 16'h0000); rd(A_TMO, rv); check("R2 tmo", rv, 0);

    // R3 zero reload: nothing fires
    wr(A_CFG, 16'h0010); wr(A_TMO, 16'h0000);
    for (int k = 0; k < 30; k++) begin @(negedge clk); pulses("R3 zero", 0); end
    rd(A_STS, rv); check("R3 zero sts", rv, 0);

    // R3 kick restarts stage one
    wr(A_TMO, 16'd5);
    repeat (3) @(negedge clk);
    wr(A_TMO, 16'd5);
    for (int k = 1; k <= 5; k++) begin @(posedge clk); @(negedge clk); check("R3 kick", irq, k == 5); end
    wr(A_STS, 16'h0001);

    // R5 timebase gate
    wr(A_CFG, 16'h0110); wr(A_TMO, 16'd1);
    for (int k = 0; k < 20; k++) begin @(negedge clk); pulses("R5 gated", 0); end
    wr(A_CFG, 16'h0010);
    @(posedge clk); @(negedge clk); check("R5 resume", irq, 1'b1);
    wr(A_TMO, 16'd0); wr(A_STS, 16'h0001);

    // R11 config rewrite restarts divider: p=2, N=2, rewrite at edge 3
    wr(A_CFG, 16'h0092); wr(A_TMO, 16'd2);
    run(11, 19, 1, 2, 0, 3, 16'h0092, 16'h0007);
    wr(A_STS, 16'h0001);

    // R4 reserved divider 14 acts as 13
    wr(A_CFG, 16'h003E); wr(A_TMO, 16'd1);
    run(exp_delay(1, 14), 2 * exp_delay(1, 14), 3, 0, 0, 0, 16'h0, 16'h0009);

    // R8 writes to event flags ignored; R9 clear rules
    wr(A_STS, 16'h000E); rd(A_STS, rv); check("R8 ro", rv, 16'h0009);
    wr(A_STS, 16'h0000); rd(A_STS, rv); check("R9 no clear", rv, 16'h0009);
    wr(A_STS, 16'h0001); rd(A_STS, rv); check("R9 clear", rv, 0);

    // Random scenarios with occasional clear on the expiry edge (R10)
    for (int s = 0; s < 150; s++) begin
      int n, p, a1, a2, d1, col;
      n  = $urandom_range(1, 10);
      p  = $urandom_range(0, 3);
      a1 = $urandom_range(0, 3);
      a2 = $urandom_range(0, 3);
      d1 = exp_delay(n, p);
      col = ($urandom_range(0, 2) == 0) ? d1 : 0;
      wr(A_CFG, 16'({$urandom_range(0, 127), 1'b0, 2'(a2), 2'(a1), 4'(p)}));
      rd(A_CFG, rv); check("R2 cfg rand", rv, 16'({2'(a2), 2'(a1), 4'(p)}));
      wr(A_TMO, 16'(n));
      run(d1, 2 * d1, a1, a2, col, 0, 16'h0, exp_sts(a1, a2));
      wr(A_STS, 16'h0001); rd(A_STS, rv); check("R9 rand clear", rv, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule